// File: doc/BRIEF.md
# Single-cycle RV32I processor core

This block is an integer processor core that completes one RV32I instruction in every clock cycle. The PC drives a read-only instruction port. The fetched word is decoded in the same cycle. Register operands, immediate, ALU result, data-memory access, writeback value and next PC all settle combinationally before the rising edge. On that edge the PC, the register file and the data memory all update together.

Instructions and data use two separate ports. Both memories are expected to return read data combinationally, within the same cycle as the address. A data write is committed at the rising edge whenever any byte-enable bit is set. The ports carry no valid/ready handshake and cannot apply back-pressure: each cycle is one instruction, so a memory that cannot answer within the cycle must stall the clock rather than the core. The core handles register and immediate arithmetic, loads, stores, conditional branches, both jumps, and the two upper-immediate forms. It has no caches, pipeline, traps, CSRs or multiply/divide.

Top module: `rvc_core`

## Requirements
- R1: While `rst_n` is low, the PC, and therefore `imem_addr`, holds `RESET_PC` (default 0). All 32 registers clear to zero.
- R2: The PC moves to PC+4 on every rising edge, except when a taken branch or a jump redirects it. PC, registers and memory change only on the rising edge.
- R3: Register 0 always reads as zero, and any write to it is dropped.
- R4: Register-register operations are selected by funct3 and bit 30 as follows: 000 add (bit 30 set gives subtract), 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 logical right shift (bit 30 set gives arithmetic right shift), 110 or, 111 and. Shift amounts use the low 5 bits of the second operand.
- R5: Immediate arithmetic uses the same funct3 codes, without the subtract variant. The immediate is inst[31:20], sign-extended from inst[31]. A shift takes its amount from inst[24:20], and bit 30 selects the arithmetic right shift.
- R6: Loads read from address rs1 plus the I immediate. funct3 selects the access: 000 signed byte, 001 signed halfword, 010 word, 100 unsigned byte, 101 unsigned halfword. The byte or halfword at the addressed lane is extended to 32 bits.
- R7: Stores write to address rs1 plus the S immediate. That immediate is inst[31:25] above inst[11:7], sign-extended. funct3 000/001/010 selects byte, halfword or word. `dmem_be` bit k enables byte lane k (`dmem_wdata[8k+7:8k]`). The enable and the data are shifted to the lane given by address bits [1:0]. Halfword and word accesses must be naturally aligned.
- R8: Branches compare rs1 with rs2. funct3 selects the condition: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. A taken branch adds the B immediate to the PC. That immediate is the S layout with inst[7] moved to bit 11, inst[31] as bit 12, and bit 0 forced to zero.
- R9: A direct jump writes PC+4 to rd and adds the J offset to the PC. The offset is inst[31] as sign, then inst[19:12], inst[20], inst[30:21], and a zero bit.
- R10: An indirect jump writes PC+4 to rd. It sets the PC to rs1 plus the I immediate with bit 0 cleared, and applies no doubling to the offset.
- R11: LUI writes inst[31:12] followed by 12 zero bits to rd. AUIPC writes that value plus the PC of the instruction to rd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state element updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address of the load or store |
| dmem_wdata | output | 32 | Store data, already placed on its byte lanes |
| dmem_be | output | 4 | Byte-lane write enables; zero when not storing |
| dmem_rdata | input | 32 | Word containing `dmem_addr`, same cycle |

## Verification
A corrupted PC is visible on `imem_addr` in the cycle right after the faulty edge. A wrong next-PC choice therefore shows up one instruction later. A corrupted register shows nothing at the ports until an instruction uses it as store data, as an address, or as a branch or jump operand. For that reason the test programs store every computed register with the next instruction, which exposes a wrong value within two cycles as a wrong word in data memory. Wrong lane steering on loads and stores shows up as a mismatched byte in a stored word, or as a wrong extension pattern in a saved load result.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int XLEN  = 32;
  localparam int BYTES = XLEN / 8;
  localparam int OFFW  = $clog2(BYTES);
  localparam int SHW   = $clog2(XLEN);

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU, ALU_XOR,
    ALU_SRL, ALU_SRA, ALU_OR, ALU_AND, ALU_PASSB
  } alu_op_e;

  typedef enum logic [2:0] {IMM_I, IMM_S, IMM_B, IMM_U, IMM_J} imm_kind_e;

  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_src_e;

  typedef struct packed {
    logic      rf_we;
    logic      a_is_pc;
    logic      b_is_imm;
    alu_op_e   alu_op;
    imm_kind_e imm_kind;
    wb_src_e   wb_src;
    logic      is_load;
    logic      is_store;
    logic      is_branch;
    logic      is_jump;
    logic      is_jalr;
  } ctrl_t;

  function automatic alu_op_e f3_to_op(logic [2:0] f3, logic alt, logic sub_ok);
    case (f3)
      3'b000:  return (alt && sub_ok) ? ALU_SUB : ALU_ADD;
      3'b001:  return ALU_SLL;
      3'b010:  return ALU_SLT;
      3'b011:  return ALU_SLTU;
      3'b100:  return ALU_XOR;
      3'b101:  return alt ? ALU_SRA : ALU_SRL;
      3'b110:  return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction
endpackage

// File: rtl/rvc_regfile.sv
module rvc_regfile import rvc_pkg::*; #(
  parameter int NREGS = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   ra,
  input  logic [AW-1:0]   rb,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b
);
  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_a = (ra == '0) ? '0 : regs[ra];
  assign rd_b = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/rvc_immgen.sv
module rvc_immgen import rvc_pkg::*; (
  input  imm_kind_e       kind,
  input  logic [31:7]     ins,
  output logic [XLEN-1:0] imm
);
  always_comb begin
    case (kind)
      IMM_S:   imm = {{20{ins[31]}}, ins[31:25], ins[11:7]};
      IMM_B:   imm = {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
      IMM_U:   imm = {ins[31:12], 12'b0};
      IMM_J:   imm = {{11{ins[31]}}, ins[31], ins[19:12], ins[20], ins[30:21], 1'b0};
      default: imm = {{20{ins[31]}}, ins[31:20]};
    endcase
  end
endmodule

// File: rtl/rvc_alu.sv
module rvc_alu import rvc_pkg::*; (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  input  logic [2:0]      cmp_f3,
  input  logic [XLEN-1:0] cmp_a,
  input  logic [XLEN-1:0] cmp_b,
  output logic            take
);
  logic [SHW-1:0] sh;
  logic eq, lt_s, lt_u, cond;

  assign sh = b[SHW-1:0];

  always_comb begin
    case (op)
      ALU_SUB:   y = a - b;
      ALU_SLL:   y = a << sh;
      ALU_SLT:   y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLTU:  y = {{(XLEN-1){1'b0}}, a < b};
      ALU_XOR:   y = a ^ b;
      ALU_SRL:   y = a >> sh;
      ALU_SRA:   y = $unsigned($signed(a) >>> sh);
      ALU_OR:    y = a | b;
      ALU_AND:   y = a & b;
      ALU_PASSB: y = b;
      default:   y = a + b;
    endcase
  end

  assign eq   = (cmp_a == cmp_b);
  assign lt_s = ($signed(cmp_a) < $signed(cmp_b));
  assign lt_u = (cmp_a < cmp_b);

  always_comb begin
    case (cmp_f3[2:1])
      2'b10:   cond = lt_s;
      2'b11:   cond = lt_u;
      default: cond = eq;
    endcase
  end

  assign take = cond ^ cmp_f3[0];
endmodule

// File: rtl/rvc_lsu.sv
module rvc_lsu import rvc_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_load,
  input  logic            is_store,
  input  logic [2:0]      f3,
  input  logic [OFFW-1:0] addr_lo,
  input  logic [XLEN-1:0] st_data,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_wdata,
  output logic [BYTES-1:0] mem_be,
  output logic [XLEN-1:0] ld_data
);
  logic [XLEN-1:0]  lane;
  logic [BYTES-1:0] mask;
  logic             sx;

  assign lane = mem_rdata >> {addr_lo, 3'b000};
  assign sx   = ~f3[2];

  always_comb begin
    case (f3[1:0])
      2'b00:   ld_data = {{(XLEN-8){sx & lane[7]}}, lane[7:0]};
      2'b01:   ld_data = {{(XLEN-16){sx & lane[15]}}, lane[15:0]};
      default: ld_data = lane;
    endcase
  end

  always_comb begin
    case (f3[1:0])
      2'b00:   mask = BYTES'(1);
      2'b01:   mask = BYTES'(3);
      default: mask = '1;
    endcase
  end

  assign mem_be    = is_store ? (mask << addr_lo) : '0;
  assign mem_wdata = st_data << {addr_lo, 3'b000};

  assert_store_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_store && f3[1:0] == 2'b00) |-> $countones(mem_be) == 1);
  assert_store_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_store && f3[1:0] == 2'b01 && !addr_lo[0]) |-> $countones(mem_be) == 2);
  assert_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_store |-> mem_be == '0);
  assert_load_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && f3 == 3'b000) |-> ld_data[XLEN-1:8] == {(XLEN-8){ld_data[7]}});
  assert_load_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && f3 == 3'b101) |-> ld_data[XLEN-1:16] == '0);
endmodule

// File: rtl/rvc_core.sv
module rvc_core import rvc_pkg::*; #(
  parameter int              NREGS    = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [XLEN-1:0]  imem_addr,
  input  logic [31:0]      imem_rdata,
  output logic [XLEN-1:0]  dmem_addr,
  output logic [XLEN-1:0]  dmem_wdata,
  output logic [BYTES-1:0] dmem_be,
  input  logic [XLEN-1:0]  dmem_rdata
);
  localparam int RAW = $clog2(NREGS);

  logic [XLEN-1:0] pc, pc_next, pc_plus4;
  logic [XLEN-1:0] imm, rs1_val, rs2_val, alu_a, alu_b, alu_y, ld_data, wb_data;
  logic [31:0]     inst;
  logic [6:0]      opcode;
  logic [2:0]      f3;
  logic [RAW-1:0]  rs1, rs2, rd;
  logic            br_take, redirect;
  ctrl_t           ctrl;

  assign inst   = imem_rdata;
  assign opcode = inst[6:0];
  assign f3     = inst[14:12];
  assign rd     = inst[7 +: RAW];
  assign rs1    = inst[15 +: RAW];
  assign rs2    = inst[20 +: RAW];

  // Decoder
  always_comb begin
    ctrl = '{rf_we: 1'b0, a_is_pc: 1'b0, b_is_imm: 1'b0, alu_op: ALU_ADD,
             imm_kind: IMM_I, wb_src: WB_ALU, is_load: 1'b0, is_store: 1'b0,
             is_branch: 1'b0, is_jump: 1'b0, is_jalr: 1'b0};
    case (opcode)
      OPC_OP: begin
        ctrl.rf_we  = 1'b1;
        ctrl.alu_op = f3_to_op(f3, inst[30], 1'b1);
      end
      OPC_OPIMM: begin
        ctrl.rf_we    = 1'b1;
        ctrl.b_is_imm = 1'b1;
        ctrl.alu_op   = f3_to_op(f3, inst[30], 1'b0);
      end
      OPC_LOAD: begin
        ctrl.rf_we    = 1'b1;
        ctrl.b_is_imm = 1'b1;
        ctrl.wb_src   = WB_MEM;
        ctrl.is_load  = 1'b1;
      end
      OPC_STORE: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.imm_kind = IMM_S;
        ctrl.is_store = 1'b1;
      end
      OPC_BRANCH: begin
        ctrl.a_is_pc   = 1'b1;
        ctrl.b_is_imm  = 1'b1;
        ctrl.imm_kind  = IMM_B;
        ctrl.is_branch = 1'b1;
      end
      OPC_JAL: begin
        ctrl.rf_we    = 1'b1;
        ctrl.a_is_pc  = 1'b1;
        ctrl.b_is_imm = 1'b1;
        ctrl.imm_kind = IMM_J;
        ctrl.wb_src   = WB_LINK;
        ctrl.is_jump  = 1'b1;
      end
      OPC_JALR: begin
        ctrl.rf_we    = 1'b1;
        ctrl.b_is_imm = 1'b1;
        ctrl.wb_src   = WB_LINK;
        ctrl.is_jump  = 1'b1;
        ctrl.is_jalr  = 1'b1;
      end
      OPC_LUI: begin
        ctrl.rf_we    = 1'b1;
        ctrl.b_is_imm = 1'b1;
        ctrl.imm_kind = IMM_U;
        ctrl.alu_op   = ALU_PASSB;
      end
      OPC_AUIPC: begin
        ctrl.rf_we    = 1'b1;
        ctrl.a_is_pc  = 1'b1;
        ctrl.b_is_imm = 1'b1;
        ctrl.imm_kind = IMM_U;
      end
      default: ;
    endcase
  end

  rvc_immgen u_imm (.kind(ctrl.imm_kind), .ins(inst[31:7]), .imm(imm));

  rvc_regfile #(.NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(ctrl.rf_we), .waddr(rd), .wdata(wb_data),
    .ra(rs1), .rb(rs2), .rd_a(rs1_val), .rd_b(rs2_val)
  );

  assign alu_a = ctrl.a_is_pc  ? pc  : rs1_val;
  assign alu_b = ctrl.b_is_imm ? imm : rs2_val;

  rvc_alu u_alu (
    .op(ctrl.alu_op), .a(alu_a), .b(alu_b), .y(alu_y),
    .cmp_f3(f3), .cmp_a(rs1_val), .cmp_b(rs2_val), .take(br_take)
  );

  rvc_lsu u_lsu (
    .clk(clk), .rst_n(rst_n), .is_load(ctrl.is_load), .is_store(ctrl.is_store),
    .f3(f3), .addr_lo(alu_y[OFFW-1:0]), .st_data(rs2_val), .mem_rdata(dmem_rdata),
    .mem_wdata(dmem_wdata), .mem_be(dmem_be), .ld_data(ld_data)
  );

  assign pc_plus4 = pc + XLEN'(4);

  always_comb begin
    case (ctrl.wb_src)
      WB_MEM:  wb_data = ld_data;
      WB_LINK: wb_data = pc_plus4;
      default: wb_data = alu_y;
    endcase
  end

  assign redirect = ctrl.is_jump || (ctrl.is_branch && br_take);
  assign pc_next  = redirect ? {alu_y[XLEN-1:1], 1'b0} : pc_plus4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= RESET_PC;
    else        pc <= pc_next;
  end

  assign imem_addr = pc;
  assign dmem_addr = alu_y;

  assert_reset_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pc == RESET_PC);
  assert_seq_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.is_jump || ctrl.is_branch) |=> pc == $past(pc) + XLEN'(4));
  assert_x0_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rs1 == '0) |-> rs1_val == '0);
  assert_branch_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.is_branch && !br_take) |=> pc == $past(pc) + XLEN'(4));
  assert_branch_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.is_branch && br_take) |=> pc == $past(pc + imm));
  assert_jal_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.is_jump && !ctrl.is_jalr) |=> pc == $past(pc + imm));
  assert_jalr_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.is_jalr |=> pc == ($past(rs1_val + imm) & ~XLEN'(1)));
  assert_lui_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OPC_LUI) |-> wb_data == {inst[31:12], 12'b0});
endmodule

// File: tb/test_rvc_core.sv
module test_rvc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic [3:0]  dmem_be;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  logic        tb_load = 1'b0;
  logic [31:0] tb_a = '0, tb_b = '0;

  int n_chk = 0;
  int n_bad = 0;
  int wp;
  int slot;
  logic [31:0] end_pc;
  logic [31:0] exp_v [64];
  string       exp_r [64];

  always #2 clk = ~clk;

  rvc_core i_rvc_core (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_be(dmem_be),
    .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk) begin
    if (tb_load) begin
      for (int i = 0; i < 256; i++) dmem[i] <= '0;
      dmem[64] <= tb_a;
      dmem[65] <= tb_b;
    end else if (rst_n) begin
      for (int k = 0; k < 4; k++)
        if (dmem_be[k]) dmem[dmem_addr[9:2]][8*k +: 8] <= dmem_wdata[8*k +: 8];
    end
  end

  // Encoders
  function automatic logic [31:0] r_t(logic [6:0] f7, logic [2:0] f3, logic [4:0] rd,
                                      logic [4:0] rs1, logic [4:0] rs2);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] i_t(logic [6:0] opc, logic [2:0] f3, logic [4:0] rd,
                                      logic [4:0] rs1, logic [11:0] im);
    return {im, rs1, f3, rd, opc};
  endfunction
  function automatic logic [31:0] s_t(logic [2:0] f3, logic [4:0] rs1, logic [4:0] rs2,
                                      logic [11:0] im);
    return {im[11:5], rs2, rs1, f3, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] b_t(logic [2:0] f3, logic [4:0] rs1, logic [4:0] rs2,
                                      logic [12:0] im);
    return {im[12], im[10:5], rs2, rs1, f3, im[4:1], im[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] u_t(logic [6:0] opc, logic [4:0] rd, logic [19:0] im);
    return {im, rd, opc};
  endfunction
  function automatic logic [31:0] j_t(logic [4:0] rd, logic [20:0] im);
    return {im[20], im[10:1], im[11], im[19:12], rd, 7'b1101111};
  endfunction

  function automatic logic [31:0] opnd(int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return 32'h1234_5678;
      6: return 32'hFEDC_BA98;
      default: return 32'h0000_0803;
    endcase
  endfunction

  task automatic put(logic [31:0] w);
    imem[wp] = w;
    wp++;
  endtask

  task automatic save(logic [4:0] r, logic [31:0] v, string req);
    put(s_t(3'b010, 5'd0, r, 12'(512 + 4 * slot)));
    exp_v[slot] = v;
    exp_r[slot] = req;
    slot++;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, expv);
    end
  endtask

  task automatic build(logic [31:0] a, logic [31:0] b);
    logic [31:0] immv, ev, p;
    logic [2:0]  f3;
    logic [6:0]  f7;
    logic [4:0]  sh;
    logic        tk;
    wp = 0;
    slot = 0;
    immv = {{20{b[11]}}, b[11:0]};
    sh = b[4:0];
    put(i_t(7'b0000011, 3'b010, 5'd1, 5'd0, 12'h100));
    put(i_t(7'b0000011, 3'b010, 5'd2, 5'd0, 12'h104));
    // R4: register-register
    for (int k = 0; k < 10; k++) begin
      f7 = 7'h00;
      case (k)
        0: begin f3 = 3'b000; ev = a + b; end
        1: begin f3 = 3'b000; f7 = 7'h20; ev = a - b; end
        2: begin f3 = 3'b001; ev = a << b[4:0]; end
        3: begin f3 = 3'b010; ev = ($signed(a) < $signed(b)) ? 1 : 0; end
        4: begin f3 = 3'b011; ev = (a < b) ? 1 : 0; end
        5: begin f3 = 3'b100; ev = a ^ b; end
        6: begin f3 = 3'b101; ev = a >> b[4:0]; end
        7: begin f3 = 3'b101; f7 = 7'h20; ev = $unsigned($signed(a) >>> b[4:0]); end
        8: begin f3 = 3'b110; ev = a | b; end
        default: begin f3 = 3'b111; ev = a & b; end
      endcase
      put(r_t(f7, f3, 5'd3, 5'd1, 5'd2));
      save(5'd3, ev, "R4");
    end
    // R8: six branch conditions, forward offset 8
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: begin f3 = 3'b000; tk = (a == b); end
        1: begin f3 = 3'b001; tk = (a != b); end
        2: begin f3 = 3'b100; tk = ($signed(a) < $signed(b)); end
        3: begin f3 = 3'b101; tk = ($signed(a) >= $signed(b)); end
        4: begin f3 = 3'b110; tk = (a < b); end
        default: begin f3 = 3'b111; tk = (a >= b); end
      endcase
      put(i_t(7'b0010011, 3'b000, 5'd13, 5'd0, 12'd0));
      put(b_t(f3, 5'd1, 5'd2, 13'd8));
      put(i_t(7'b0010011, 3'b000, 5'd13, 5'd0, 12'd1));
      save(5'd13, tk ? 32'd0 : 32'd1, "R8");
    end
    // R5: immediate arithmetic
    for (int k = 0; k < 9; k++) begin
      case (k)
        0: begin put(i_t(7'b0010011, 3'b000, 5'd14, 5'd1, b[11:0])); ev = a + immv; end
        1: begin put(i_t(7'b0010011, 3'b010, 5'd14, 5'd1, b[11:0]));
                 ev = ($signed(a) < $signed(immv)) ? 1 : 0; end
        2: begin put(i_t(7'b0010011, 3'b011, 5'd14, 5'd1, b[11:0])); ev = (a < immv) ? 1 : 0; end
        3: begin put(i_t(7'b0010011, 3'b100, 5'd14, 5'd1, b[11:0])); ev = a ^ immv; end
        4: begin put(i_t(7'b0010011, 3'b110, 5'd14, 5'd1, b[11:0])); ev = a | immv; end
        5: begin put(i_t(7'b0010011, 3'b111, 5'd14, 5'd1, b[11:0])); ev = a & immv; end
        6: begin put(i_t(7'b0010011, 3'b001, 5'd14, 5'd1, {7'h00, sh})); ev = a << sh; end
        7: begin put(i_t(7'b0010011, 3'b101, 5'd14, 5'd1, {7'h00, sh})); ev = a >> sh; end
        default: begin put(i_t(7'b0010011, 3'b101, 5'd14, 5'd1, {7'h20, sh}));
                       ev = $unsigned($signed(a) >>> sh); end
      endcase
      save(5'd14, ev, "R5");
    end
    // R6: narrow loads from the word holding a
    put(s_t(3'b010, 5'd0, 5'd1, 12'h108));
    for (int k = 0; k < 4; k++) begin
      put(i_t(7'b0000011, 3'b000, 5'd24, 5'd0, 12'(264 + k)));
      save(5'd24, {{24{a[8*k+7]}}, a[8*k +: 8]}, "R6");
      put(i_t(7'b0000011, 3'b100, 5'd24, 5'd0, 12'(264 + k)));
      save(5'd24, {24'h0, a[8*k +: 8]}, "R6");
    end
    for (int k = 0; k < 2; k++) begin
      put(i_t(7'b0000011, 3'b001, 5'd24, 5'd0, 12'(264 + 2 * k)));
      save(5'd24, {{16{a[16*k+15]}}, a[16*k +: 16]}, "R6");
      put(i_t(7'b0000011, 3'b101, 5'd24, 5'd0, 12'(264 + 2 * k)));
      save(5'd24, {16'h0, a[16*k +: 16]}, "R6");
    end
    // R7: byte and halfword stores into words 0x10C and 0x110
    put(s_t(3'b010, 5'd0, 5'd1, 12'h10C));
    put(s_t(3'b000, 5'd0, 5'd2, 12'h10D));
    put(s_t(3'b001, 5'd0, 5'd2, 12'h10E));
    put(s_t(3'b010, 5'd0, 5'd1, 12'h110));
    put(s_t(3'b001, 5'd0, 5'd2, 12'h110));
    put(s_t(3'b000, 5'd0, 5'd2, 12'h113));
    // R11: upper immediates
    put(u_t(7'b0110111, 5'd15, a[31:12]));
    save(5'd15, {a[31:12], 12'h0}, "R11");
    p = 32'(wp * 4);
    put(u_t(7'b0010111, 5'd16, b[31:12]));
    save(5'd16, p + {b[31:12], 12'h0}, "R11");
    // R9: direct jump skips one instruction
    put(i_t(7'b0010011, 3'b000, 5'd18, 5'd0, 12'd0));
    p = 32'(wp * 4);
    put(j_t(5'd17, 21'd8));
    put(i_t(7'b0010011, 3'b000, 5'd18, 5'd0, 12'd5));
    save(5'd17, p + 4, "R9");
    save(5'd18, 32'd0, "R9");
    // R10: indirect jump, odd offset 13 lands on +12
    p = 32'(wp * 4);
    put(u_t(7'b0010111, 5'd19, 20'h0));
    put(i_t(7'b1100111, 3'b000, 5'd20, 5'd19, 12'd13));
    put(i_t(7'b0010011, 3'b000, 5'd18, 5'd0, 12'd7));
    save(5'd20, p + 8, "R10");
    save(5'd18, 32'd0, "R10");
    // R8: backward branch loop, three passes
    put(i_t(7'b0010011, 3'b000, 5'd22, 5'd0, 12'd3));
    put(i_t(7'b0010011, 3'b000, 5'd23, 5'd0, 12'd0));
    put(i_t(7'b0010011, 3'b000, 5'd23, 5'd23, 12'd1));
    put(i_t(7'b0010011, 3'b000, 5'd22, 5'd22, 12'hFFF));
    put(b_t(3'b001, 5'd22, 5'd0, 13'h1FF8));
    save(5'd23, 32'd3, "R8");
    // R3: writes to register 0 are dropped
    put(i_t(7'b0010011, 3'b000, 5'd0, 5'd0, 12'd123));
    put(r_t(7'h00, 3'b000, 5'd0, 5'd1, 5'd2));
    save(5'd0, 32'd0, "R3");
    end_pc = 32'(wp * 4);
    put(j_t(5'd0, 21'd0));
  endtask

  task automatic run_pair(logic [31:0] a, logic [31:0] b);
    int n;
    rst_n = 1'b0;
    build(a, b);
    tb_a = a;
    tb_b = b;
    tb_load = 1'b1;
    @(negedge clk);
    @(negedge clk);
    tb_load = 1'b0;
    check("R1", imem_addr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", imem_addr, 32'h4);
    n = 0;
    while (imem_addr !== end_pc && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    check("R9", imem_addr, end_pc);
    for (int s = 0; s < slot; s++)
      check(exp_r[s], dmem[128 + s], exp_v[s]);
    check("R7", dmem[67], {b[15:0], b[7:0], a[7:0]});
    check("R7", dmem[68], {b[7:0], a[23:16], b[15:0]});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) imem[i] = 32'h0000_0013;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        run_pair(opnd(i), opnd(j));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule